// File: doc/BRIEF.md
# Interrupt Pending Controller with Channel Loop Flags

This block gathers single-cycle event pulses into a 32-bit pending word. A 32-bit enable word sits beside it. Together they drive one active-low interrupt line. Software reads both words through a small register port. It acknowledges pending events by writing ones to the bits it wants cleared.

The block also keeps 64 per-channel loop flags, which are set by per-channel pulses. These flags are not stored in the pending word. Instead, bit 6 of the pending word is a summary that reads one while any flag is set. Bits 5:0 then give the number of the highest set channel. Software handles the reported channel and writes the same value back with bit 6 set. That write clears only that channel's flag. The summary then moves on to the next highest set channel.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, the pending word reads 0, the enable word reads 0, all loop flags are clear and `irq_n` is 1.
- R2: A write with `reg_sel`=0 clears each pending bit in 31:7 whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R3: A pulse on `evt_pulse[b]` sets pending bit b, for b in 31:7. Pulses on `evt_pulse[6:0]` have no effect on the pending word.
- R4: An event or loop-flag pulse in the same cycle as a write that would clear that bit or flag wins: the bit or flag stays set.
- R5: A pulse on `loop_set[c]` sets loop flag c. Pending bit 6 reads 1 exactly while at least one loop flag is set.
- R6: Pending bits 5:0 read the index of the highest-numbered set loop flag, and read 0 when no flag is set.
- R7: A pending write with data bit 6 set clears only the loop flag whose index is in data bits 5:0. Writes with data bit 6 clear touch no loop flag.
- R8: A write with `reg_sel`=1 loads all 32 bits of the enable word, and the enable word reads back unchanged.
- R9: `irq_n` is 0 exactly when one of these holds: (pending[31:7] AND enable[31:7]) is nonzero; pending bit 6 and enable bit 6 are both 1; or the force bit, enable bit 0, is 1.
- R10: Every register update appears on `reg_rdata` and `irq_n` right after the clock edge that samples the stimulus. There is no combinational path from inputs to `irq_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | 0 selects the pending word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word, combinational from state |
| evt_pulse | input | 32 | Single-cycle event pulses; bits 31:7 are used |
| loop_set | input | 64 | Single-cycle per-channel loop pulses |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
Every result is due one clock edge after the stimulus. The pending bits, loop flags and enable word each sit behind exactly one register, and `irq_n` and `reg_rdata` are decoded from those registers only. The bench applies stimulus after a falling edge. It updates its model at the rising edge. A quarter period later it checks `irq_n`, then switches `reg_sel` to compare both words before the next edge. Random traffic runs from a fixed seed. Directed cases cover reset, same-cycle priority, walking the summary down through clears, and the force bit.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_CHAN  = 64;
    localparam int CHAN_W    = $clog2(NUM_CHAN);
    localparam int SUM_BIT   = 6;
    localparam int SRC_LO    = SUM_BIT + 1;
    localparam int SRC_W     = WORD_W - SRC_LO;
    localparam int FORCE_BIT = 0;

    typedef struct packed {
        logic [SRC_W-1:0]  pend;
        logic [WORD_W-1:0] en;
    } ctrl_state_t;
endpackage

// File: rtl/irq_loop_flags.sv
module irq_loop_flags #(
    parameter int NCH = 64,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic           clr_en,
    input  logic [CW-1:0]  clr_idx,
    output logic [NCH-1:0] flags_q
);
    logic [NCH-1:0] flags_d;
    logic [NCH-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_idx] = 1'b1;
        // a set pulse outranks a clear of the same channel
        flags_d = (flags_q & ~clr_mask) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 64,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [WORD_W-1:0]   evt_pulse,
    input  logic [NUM_CHAN-1:0] loop_set,
    output logic                irq_n
);
    ctrl_state_t st_d, st_q;

    logic                pend_wr;
    logic                loop_clr;
    logic [NUM_CHAN-1:0] flags_q;
    logic                loop_any;
    logic [CHAN_W-1:0]   loop_idx;
    logic [SRC_W-1:0]    pend_q;
    logic [WORD_W-1:0]   en_q;
    logic [WORD_W-1:0]   pend_view;

    assign pend_wr  = reg_wr && !reg_sel;
    assign loop_clr = pend_wr && reg_wdata[SUM_BIT];

    irq_loop_flags #(.NCH(NUM_CHAN)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (loop_set),
        .clr_en  (loop_clr),
        .clr_idx (reg_wdata[CHAN_W-1:0]),
        .flags_q (flags_q)
    );

    irq_prio_enc #(.N(NUM_CHAN)) u_enc (
        .vec (flags_q),
        .any (loop_any),
        .idx (loop_idx)
    );

    always_comb begin
        st_d = st_q;
        if (pend_wr) st_d.pend = st_d.pend & ~reg_wdata[WORD_W-1:SRC_LO];
        st_d.pend = st_d.pend | evt_pulse[WORD_W-1:SRC_LO];
        if (reg_wr && reg_sel) st_d.en = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
    assign en_q   = st_q.en;

    always_comb begin
        pend_view = '0;
        pend_view[WORD_W-1:SRC_LO] = pend_q;
        pend_view[SUM_BIT]         = loop_any;
        pend_view[CHAN_W-1:0]      = loop_any ? loop_idx : '0;
    end

    assign reg_rdata = reg_sel ? en_q : pend_view;

    assign irq_n = !( (|(pend_q & en_q[WORD_W-1:SRC_LO]))
                   || (loop_any && en_q[SUM_BIT])
                   || en_q[FORCE_BIT] );
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk
    import irq_pend_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic                reg_sel,
    input logic [WORD_W-1:0]   reg_wdata,
    input logic [WORD_W-1:0]   evt_pulse,
    input logic [NUM_CHAN-1:0] loop_set,
    input logic                irq_n,
    input logic [SRC_W-1:0]    pend_q,
    input logic [WORD_W-1:0]   en_q,
    input logic [NUM_CHAN-1:0] flags_q,
    input logic                loop_any,
    input logic [CHAN_W-1:0]   loop_idx
);
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && ((reg_wdata[WORD_W-1:SRC_LO] & evt_pulse[WORD_W-1:SRC_LO]) == '0))
        |=> ((pend_q & $past(reg_wdata[WORD_W-1:SRC_LO])) == '0));

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[WORD_W-1:SRC_LO] != '0)
        |=> ((pend_q & $past(evt_pulse[WORD_W-1:SRC_LO])) == $past(evt_pulse[WORD_W-1:SRC_LO])));

    a_r4_loop_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_set != '0) |=> ((flags_q & $past(loop_set)) == $past(loop_set)));

    a_r6_highest_index: assert property (@(posedge clk) disable iff (!rst_n)
        loop_any |-> ((flags_q >> loop_idx) == 64'd1));

    a_r7_loop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[SUM_BIT] && !loop_set[reg_wdata[CHAN_W-1:0]])
        |=> !flags_q[$past(reg_wdata[CHAN_W-1:0])]);

    a_r9_force_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[FORCE_BIT] |-> !irq_n);

    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> irq_n);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .evt_pulse (evt_pulse),
    .loop_set  (loop_set),
    .irq_n     (irq_n),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .flags_q   (flags_q),
    .loop_any  (loop_any),
    .loop_idx  (loop_idx)
);

// File: tb/irq_pend_ctrl_test.sv
module irq_pend_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 20240611;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic        reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] evt_pulse;
    logic [63:0] loop_set;
    logic        irq_n;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_pend;   // bits 31:7 only
    logic [31:0] m_en;
    logic [63:0] m_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .loop_set  (loop_set),
        .irq_n     (irq_n)
    );

    function automatic logic [31:0] exp_pend_view();
        logic [31:0] v = m_pend & 32'hFFFF_FF80;
        for (int i = 0; i < 64; i++) begin
            if (m_flags[i]) v[6:0] = {1'b1, 6'(i)};
        end
        return v;
    endfunction

    function automatic logic exp_irq_n();
        logic [31:0] v = exp_pend_view();
        return !(((v[31:7] & m_en[31:7]) != '0) || (v[6] && m_en[6]) || m_en[0]);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic observe(input string tag);
        check({tag, " R9 irq_n"}, {31'd0, irq_n}, {31'd0, exp_irq_n()});
        reg_sel = 1'b0;
        #1;
        check({tag, " R5/R6 pending"}, reg_rdata, exp_pend_view());
        reg_sel = 1'b1;
        #1;
        check({tag, " R8 enable"}, reg_rdata, m_en);
    endtask

    // one cycle of stimulus; R10: results are checked right after the sampling edge
    task automatic cyc(input logic wr, input logic sel, input logic [31:0] wd,
                       input logic [31:0] ev, input logic [63:0] ls, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; evt_pulse = ev; loop_set = ls;
        @(posedge clk);
        if (wr && !sel) begin
            m_pend = m_pend & ~wd;
            if (wd[6]) m_flags[wd[5:0]] = 1'b0;
        end
        if (wr && sel) m_en = wd;
        m_pend  = (m_pend | ev) & 32'hFFFF_FF80;
        m_flags = m_flags | ls;
        #(CLK_PERIOD/4);
        reg_wr = 1'b0; evt_pulse = '0; loop_set = '0;
        observe(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(SEED));
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        evt_pulse = '0; loop_set = '0;
        m_pend = '0; m_en = '0; m_flags = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        observe("R1 reset");

        // R3: low event lines ignored, high ones set
        cyc(0, 0, 0, 32'h0000_007F, 0, "R3 low lines");
        cyc(0, 0, 0, 32'h0000_C380, 0, "R3 set");
        // R2: clear some, leave others
        cyc(1, 0, 32'h0000_4200, 0, 0, "R2 w1c");
        // R4: event and clear same cycle
        cyc(1, 0, 32'h0000_8080, 32'h0000_8000, 0, "R4 evt wins");
        // R9: enable masks
        cyc(1, 1, 32'h0000_0100, 0, 0, "R9 masked");
        cyc(1, 1, 32'h0000_8000, 0, 0, "R9 unmasked");
        // R5/R6: loop flags, summary walks down
        cyc(0, 0, 0, 0, 64'h8000_0000_0000_0021, "R5 set");
        cyc(1, 1, 32'h0000_0040, 0, 0, "R9 summary en");
        cyc(1, 0, 32'h0000_007F, 0, 0, "R7 clr 63");
        cyc(1, 0, 32'h0000_0005, 0, 0, "R7 no bit6");
        cyc(1, 0, 32'h0000_0045, 0, 0, "R7 clr 5");
        cyc(1, 0, 32'h0000_0041, 0, 64'h2, "R4 set wins");
        cyc(1, 0, 32'h0000_0040, 0, 0, "R7 clr 0 only");
        cyc(1, 0, 32'h0000_0041, 0, 0, "R6 empty zero");
        // R9 force bit
        cyc(1, 0, 32'hFFFF_FF80, 0, 0, "R2 clear all");
        cyc(1, 1, 32'h0000_0001, 0, 0, "R9 force");
        cyc(1, 1, 32'h0000_0000, 0, 0, "R9 release");

        // constrained random traffic
        for (int n = 0; n < 600; n++) begin
            logic        wr  = ($urandom % 10) < 4;
            logic        sel = ($urandom % 4) == 0;
            logic [31:0] wd  = $urandom;
            logic [31:0] ev  = $urandom & $urandom & $urandom;
            logic [63:0] ls  = {$urandom, $urandom} & {$urandom, $urandom}
                             & {$urandom, $urandom} & {$urandom, $urandom};
            if (sel) wd[0] = ($urandom % 8) == 0;
            if (!sel && wr && ($urandom % 2)) wd = {25'd0, 1'b1, exp_pend_view()[5:0]};
            cyc(wr, sel, wd, ev, ls, "R2/R3/R4/R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule